// File: doc/BRIEF.md
# Width-Selectable Overflow and Sign Status Flags

This block keeps three processor status bits: a data-width mode bit, an overflow flag and a negative flag. When the mode bit is 0 the machine works on 16-bit data; when it is 1 it works on 8-bit data. After each datapath operation the surrounding core presents the operands, the result and an operation code. The block then works out the overflow and negative flags at the width in force and stores them.

Explicit set-flags and clear-flags commands carry a bit mask. There are also two dedicated commands, clear-mode and clear-overflow. These let the program change the flags directly, and an explicit command always beats an arithmetic update in the same cycle. A decimal-mode input freezes both flags during add and subtract, because they carry no meaning there. Four combinational branch-condition outputs report overflow set, overflow clear, minus and plus for conditional branches.

The narrow and wide widths are parameters. A generate option picks how overflow is found: from the sign bits of the operands and result, or by comparing a widened sum against the signed range.

Top module: `wsel_status_flags`

## Requirements
- R1: After reset the mode bit, the overflow flag and the negative flag are all 0.
- R2: A set-flags command whose mask bit 0 is 1 sets the mode bit. A clear-mode command clears it, and so does a clear-flags command whose mask bit 0 is 1. Mode 0 selects the wide width (16 bits) and mode 1 the narrow width (8 bits).
- R3: In wide mode, add (op 1) and subtract (op 2, minuend on operand A) set overflow when the true signed result of A+B or A−B lies outside −32768..+32767, and clear it otherwise.
- R4: In narrow mode, add and subtract set overflow when the signed 8-bit result lies outside −128..+127 and clear it otherwise. Bits 15..8 of the operands have no effect.
- R5: A divide-check (op 3) loads overflow with the divide-too-wide input and leaves negative unchanged. Decimal mode does not stop this.
- R6: Add, subtract and transfer (op 4) load negative from result bit 15 in wide mode and from bit 7 in narrow mode. Transfer leaves overflow unchanged.
- R7: While decimal mode is high, add and subtract leave both overflow and negative unchanged.
- R8: Overflow is set by a set-flags command with mask bit 1. It is cleared by clear-overflow or by clear-flags with mask bit 1. Negative is set or cleared by set-flags or clear-flags with mask bit 2.
- R9: For each bit, an explicit command in a cycle overrides that cycle's arithmetic update. If set-flags and clear-flags both name the same bit, set wins.
- R10: The branch outputs follow the stored flags in the same cycle: overflow-set equals overflow, overflow-clear is its inverse, minus equals negative, and plus is its inverse.
- R11: With op 0 (no-op) and no command, all three stored bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 3 | Operation: 0 no-op, 1 add, 2 subtract, 3 divide-check, 4 transfer |
| opnd_a | input | 16 | Operand A (minuend for subtract) |
| opnd_b | input | 16 | Operand B |
| result | input | 16 | Datapath result of the operation |
| div_too_wide | input | 1 | Divide quotient does not fit the destination width |
| dec_mode | input | 1 | Decimal mode active |
| set_flags | input | 1 | Set the status bits named in flag_mask |
| clr_flags | input | 1 | Clear the status bits named in flag_mask |
| flag_mask | input | 3 | Bit 0 mode, bit 1 overflow, bit 2 negative |
| clr_mode | input | 1 | Clear the mode bit |
| clr_ovf | input | 1 | Clear the overflow flag |
| mode_narrow | output | 1 | Mode bit: 1 selects the narrow width |
| flag_ovf | output | 1 | Overflow flag |
| flag_neg | output | 1 | Negative flag |
| br_ovf_set | output | 1 | Branch condition: overflow set |
| br_ovf_clr | output | 1 | Branch condition: overflow clear |
| br_minus | output | 1 | Branch condition: negative set |
| br_plus | output | 1 | Branch condition: negative clear |

## Verification
A wrong mode bit picks the wrong sign position and overflow range. It shows up on the overflow and negative outputs in the cycle after the next add or transfer whose upper and lower bytes disagree. A flag lost or kept wrongly through a decimal-mode add, a no-op or a command collision shows on the flag and branch outputs one cycle after that operation. The sweeps put operands across both range edges in each width, with unrelated upper bytes in narrow mode, so such errors surface within a few cycles.

// File: rtl/wsf_pkg.sv
package wsf_pkg;
   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_ADD  = 3'd1,
      OP_SUB  = 3'd2,
      OP_DIV  = 3'd3,
      OP_XFER = 3'd4
   } wsf_op_e;

   localparam int NUM_BITS = 3;
   localparam int BIT_MODE = 0;
   localparam int BIT_OVF  = 1;
   localparam int BIT_NEG  = 2;
endpackage

// File: rtl/wsf_width_sel.sv
module wsf_width_sel #(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic              narrow,
   input  logic [WIDE_W-1:0] a,
   input  logic [WIDE_W-1:0] b,
   input  logic [WIDE_W-1:0] r,
   output logic              sgn_a,
   output logic              sgn_b,
   output logic              sgn_r,
   output logic [WIDE_W-1:0] a_sx,
   output logic [WIDE_W-1:0] b_sx
);
   localparam int EXT_W = WIDE_W - NARROW_W;

   logic [WIDE_W-1:0] a_n;
   logic [WIDE_W-1:0] b_n;

   always_comb begin
      a_n = {{EXT_W{a[NARROW_W-1]}}, a[NARROW_W-1:0]};
      b_n = {{EXT_W{b[NARROW_W-1]}}, b[NARROW_W-1:0]};
      sgn_a = narrow ? a[NARROW_W-1] : a[WIDE_W-1];
      sgn_b = narrow ? b[NARROW_W-1] : b[WIDE_W-1];
      sgn_r = narrow ? r[NARROW_W-1] : r[WIDE_W-1];
      a_sx  = narrow ? a_n : a;
      b_sx  = narrow ? b_n : b;
   end
endmodule

// File: rtl/wsf_ovf_calc.sv
module wsf_ovf_calc #(
   parameter int WIDE_W    = 16,
   parameter int NARROW_W  = 8,
   parameter int OVF_STYLE = 0
) (
   input  logic              narrow,
   input  logic              is_sub,
   input  logic              sgn_a,
   input  logic              sgn_b,
   input  logic              sgn_r,
   input  logic [WIDE_W-1:0] a_sx,
   input  logic [WIDE_W-1:0] b_sx,
   output logic              ovf
);
   localparam int XW = WIDE_W + 1;

   generate
      if (OVF_STYLE == 0) begin : g_sign
         always_comb begin
            if (is_sub)
               ovf = (sgn_a != sgn_b) && (sgn_r != sgn_a);
            else
               ovf = (sgn_a == sgn_b) && (sgn_r != sgn_a);
         end
      end else begin : g_range
         localparam logic signed [XW-1:0] HI_W =
            {2'b00, {(WIDE_W-1){1'b1}}};
         localparam logic signed [XW-1:0] LO_W =
            {2'b11, {(WIDE_W-1){1'b0}}};
         localparam logic signed [XW-1:0] HI_N =
            {{(XW-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
         localparam logic signed [XW-1:0] LO_N =
            {{(XW-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

         logic signed [XW-1:0] ax;
         logic signed [XW-1:0] bx;
         logic signed [XW-1:0] sum;
         logic signed [XW-1:0] hi;
         logic signed [XW-1:0] lo;

         always_comb begin
            ax  = $signed({a_sx[WIDE_W-1], a_sx});
            bx  = $signed({b_sx[WIDE_W-1], b_sx});
            sum = is_sub ? (ax - bx) : (ax + bx);
            hi  = narrow ? HI_N : HI_W;
            lo  = narrow ? LO_N : LO_W;
            ovf = (sum > hi) || (sum < lo);
         end
      end
   endgenerate
endmodule

// File: rtl/wsf_flag_reg.sv
module wsf_flag_reg
   import wsf_pkg::*;
#(
   parameter int N_BITS = NUM_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_BITS-1:0] upd,
   input  logic [N_BITS-1:0] nxt,
   input  logic              set_flags,
   input  logic              clr_flags,
   input  logic [N_BITS-1:0] mask,
   input  logic [N_BITS-1:0] clr_extra,
   output logic [N_BITS-1:0] q
);
   logic [N_BITS-1:0] set_v;
   logic [N_BITS-1:0] clr_v;

   generate
      for (genvar i = 0; i < N_BITS; i++) begin : g_bit
         always_comb begin
            set_v[i] = set_flags && mask[i];
            clr_v[i] = (clr_flags && mask[i]) || clr_extra[i];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[i] <= 1'b0;
            else if (set_v[i])
               q[i] <= 1'b1;
            else if (clr_v[i])
               q[i] <= 1'b0;
            else if (upd[i])
               q[i] <= nxt[i];
         end

         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (set_flags && mask[i]) |=> q[i]); // R9

         AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (!(set_flags && mask[i]) && ((clr_flags && mask[i]) || clr_extra[i])) |=> !q[i]); // R8
      end
   endgenerate
endmodule

// File: rtl/wsf_branch.sv
module wsf_branch (
   input  logic ovf,
   input  logic neg,
   output logic br_ovf_set,
   output logic br_ovf_clr,
   output logic br_minus,
   output logic br_plus
);
   always_comb begin
      br_ovf_set = ovf;
      br_ovf_clr = !ovf;
      br_minus   = neg;
      br_plus    = !neg;
   end
endmodule

// File: rtl/wsel_status_flags.sv
module wsel_status_flags
   import wsf_pkg::*;
#(
   parameter int WIDE_W    = 16,
   parameter int NARROW_W  = 8,
   parameter int OVF_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op,
   input  logic [WIDE_W-1:0] opnd_a,
   input  logic [WIDE_W-1:0] opnd_b,
   input  logic [WIDE_W-1:0] result,
   input  logic              div_too_wide,
   input  logic              dec_mode,
   input  logic              set_flags,
   input  logic              clr_flags,
   input  logic [2:0]        flag_mask,
   input  logic              clr_mode,
   input  logic              clr_ovf,
   output logic              mode_narrow,
   output logic              flag_ovf,
   output logic              flag_neg,
   output logic              br_ovf_set,
   output logic              br_ovf_clr,
   output logic              br_minus,
   output logic              br_plus
);
   generate
      if (NARROW_W < 2 || NARROW_W >= WIDE_W) begin : g_bad_width
         $error("wsel_status_flags: NARROW_W must lie in 2..WIDE_W-1");
      end
      if (OVF_STYLE != 0 && OVF_STYLE != 1) begin : g_bad_style
         $error("wsel_status_flags: OVF_STYLE must be 0 or 1");
      end
   endgenerate

   wsf_op_e op_e;
   logic    is_addsub;
   logic    is_div;
   logic    is_xfer;
   logic    sgn_a, sgn_b, sgn_r;
   logic    ovf_arith;
   logic    arith_live;
   logic [WIDE_W-1:0]   a_sx, b_sx;
   logic [NUM_BITS-1:0] upd, nxt, clr_extra, q;

   always_comb begin
      op_e       = wsf_op_e'(op);
      is_addsub  = (op_e == OP_ADD) || (op_e == OP_SUB);
      is_div     = (op_e == OP_DIV);
      is_xfer    = (op_e == OP_XFER);
      arith_live = is_addsub && !dec_mode;
   end

   wsf_width_sel #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_wsel (
      .narrow (q[BIT_MODE]),
      .a      (opnd_a),
      .b      (opnd_b),
      .r      (result),
      .sgn_a  (sgn_a),
      .sgn_b  (sgn_b),
      .sgn_r  (sgn_r),
      .a_sx   (a_sx),
      .b_sx   (b_sx)
   );

   wsf_ovf_calc #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .OVF_STYLE(OVF_STYLE)) u_ovf (
      .narrow (q[BIT_MODE]),
      .is_sub (op_e == OP_SUB),
      .sgn_a  (sgn_a),
      .sgn_b  (sgn_b),
      .sgn_r  (sgn_r),
      .a_sx   (a_sx),
      .b_sx   (b_sx),
      .ovf    (ovf_arith)
   );

   always_comb begin
      upd[BIT_MODE]       = 1'b0;
      nxt[BIT_MODE]       = 1'b0;
      upd[BIT_OVF]        = arith_live || is_div;
      nxt[BIT_OVF]        = is_div ? div_too_wide : ovf_arith;
      upd[BIT_NEG]        = arith_live || is_xfer;
      nxt[BIT_NEG]        = sgn_r;
      clr_extra[BIT_MODE] = clr_mode;
      clr_extra[BIT_OVF]  = clr_ovf;
      clr_extra[BIT_NEG]  = 1'b0;
   end

   wsf_flag_reg #(.N_BITS(NUM_BITS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (upd),
      .nxt       (nxt),
      .set_flags (set_flags),
      .clr_flags (clr_flags),
      .mask      (flag_mask),
      .clr_extra (clr_extra),
      .q         (q)
   );

   wsf_branch u_br (
      .ovf        (q[BIT_OVF]),
      .neg        (q[BIT_NEG]),
      .br_ovf_set (br_ovf_set),
      .br_ovf_clr (br_ovf_clr),
      .br_minus   (br_minus),
      .br_plus    (br_plus)
   );

   assign mode_narrow = q[BIT_MODE];
   assign flag_ovf    = q[BIT_OVF];
   assign flag_neg    = q[BIT_NEG];

   AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_mode && is_addsub && !set_flags && !clr_flags && !clr_ovf)
      |=> ($stable(flag_ovf) && $stable(flag_neg))); // R7

   AST_DIV_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (is_div && div_too_wide && !clr_flags && !clr_ovf) |=> flag_ovf); // R5

   AST_NEG_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (is_xfer && mode_narrow && !set_flags && !clr_flags)
      |=> (flag_neg == $past(result[NARROW_W-1]))); // R6

   AST_BR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (br_minus == flag_neg) && (br_ovf_set == flag_ovf)); // R10
endmodule

// File: tb/test_wsel_status_flags.sv
`timescale 1ns/1ps
module test_wsel_status_flags;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  op;
   logic [15:0] opnd_a, opnd_b, result;
   logic        div_too_wide, dec_mode;
   logic        set_flags, clr_flags, clr_mode, clr_ovf;
   logic [2:0]  flag_mask;
   logic        mode_narrow, flag_ovf, flag_neg;
   logic        br_ovf_set, br_ovf_clr, br_minus, br_plus;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;
   bit m_mode = 0, m_v = 0, m_n = 0;

   always #4 clk = ~clk;

   wsel_status_flags i_wsel_status_flags (
      .clk(clk), .rst_n(rst_n), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .result(result), .div_too_wide(div_too_wide), .dec_mode(dec_mode),
      .set_flags(set_flags), .clr_flags(clr_flags), .flag_mask(flag_mask),
      .clr_mode(clr_mode), .clr_ovf(clr_ovf), .mode_narrow(mode_narrow),
      .flag_ovf(flag_ovf), .flag_neg(flag_neg), .br_ovf_set(br_ovf_set),
      .br_ovf_clr(br_ovf_clr), .br_minus(br_minus), .br_plus(br_plus)
   );

   task automatic chk(string tag);
      logic [6:0] act, exp;
      act = {mode_narrow, flag_ovf, flag_neg, br_ovf_set, br_ovf_clr, br_minus, br_plus};
      exp = {m_mode, m_v, m_n, m_v, !m_v, m_n, !m_n};
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // Apply one cycle of stimulus, advance the model, check at the next falling edge.
   task automatic step(string tag, logic [2:0] o, logic [15:0] a, logic [15:0] b,
                       logic [15:0] r, logic dw, logic dec, logic sf, logic cf,
                       logic [2:0] mk, logic cm, logic cv);
      int  sa, sb, s;
      bit  av, nm, nv, nn;
      op = o; opnd_a = a; opnd_b = b; result = r; div_too_wide = dw; dec_mode = dec;
      set_flags = sf; clr_flags = cf; flag_mask = mk; clr_mode = cm; clr_ovf = cv;
      if (m_mode) begin
         sa = int'($signed(a[7:0])); sb = int'($signed(b[7:0]));
      end else begin
         sa = int'($signed(a)); sb = int'($signed(b));
      end
      s  = (o == 3'd2) ? sa - sb : sa + sb;
      av = m_mode ? (s > 127 || s < -128) : (s > 32767 || s < -32768);
      nm = m_mode; nv = m_v; nn = m_n;
      if ((o == 3'd1 || o == 3'd2) && !dec) begin
         nv = av; nn = m_mode ? r[7] : r[15];
      end
      if (o == 3'd3) nv = dw;
      if (o == 3'd4) nn = m_mode ? r[7] : r[15];
      if ((cf && mk[0]) || cm) nm = 0;
      if ((cf && mk[1]) || cv) nv = 0;
      if (cf && mk[2]) nn = 0;
      if (sf && mk[0]) nm = 1;
      if (sf && mk[1]) nv = 1;
      if (sf && mk[2]) nn = 1;
      @(posedge clk);
      m_mode = nm; m_v = nv; m_n = nn;
      @(negedge clk);
      chk(tag);
   endtask

   task automatic arith(string tag, logic [2:0] o, logic [15:0] a, logic [15:0] b, logic dec);
      logic [15:0] r;
      r = (o == 3'd2) ? a - b : a + b;
      if (m_mode) r[15:8] = 8'($urandom_range(255));
      step(tag, o, a, b, r, 1'b0, dec, 0, 0, 3'b000, 0, 0);
   endtask

   task automatic cmd(string tag, logic sf, logic cf, logic [2:0] mk, logic cm, logic cv);
      step(tag, 3'd0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, sf, cf, mk, cm, cv);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; op = 0; opnd_a = 0; opnd_b = 0; result = 0; div_too_wide = 0;
      dec_mode = 0; set_flags = 0; clr_flags = 0; flag_mask = 0; clr_mode = 0; clr_ovf = 0;
      repeat (3) @(negedge clk);
      chk("R1 reset");
      rst_n = 1;
      @(negedge clk);
      chk("R1 after release");

      // R8 explicit commands
      cmd("R8 set ovf+neg", 1, 0, 3'b110, 0, 0);
      cmd("R8 clear-ovf",   0, 0, 3'b000, 0, 1);
      cmd("R8 clear neg",   0, 1, 3'b100, 0, 0);
      cmd("R8 set ovf",     1, 0, 3'b010, 0, 0);
      cmd("R8 clear-flags ovf", 0, 1, 3'b010, 0, 0);
      // R10 branch outputs are checked in every chk; R11 no-op hold
      cmd("R8 set neg", 1, 0, 3'b100, 0, 0);
      step("R11 nop hold", 3'd0, 16'hFFFF, 16'h7FFF, 16'h8000, 1'b1, 1'b0, 0, 0, 3'b111, 0, 0);

      // R3 wide sweep
      for (int i = 0; i < 64; i++) begin
         for (int j = 0; j < 64; j++) begin
            logic [15:0] a, b;
            a = 16'(i * 1031) ^ (i[0] ? 16'h8000 : 16'h7F00);
            b = 16'(j * 2053) ^ (j[1] ? 16'h7FFF : 16'h8001);
            arith("R3 wide add", 3'd1, a, b, 1'b0);
            arith("R3 wide sub", 3'd2, a, b, 1'b0);
         end
      end
      arith("R3 +max+1",  3'd1, 16'h7FFF, 16'h0001, 1'b0);
      arith("R3 min-1",   3'd2, 16'h8000, 16'h0001, 1'b0);
      arith("R3 min+min", 3'd1, 16'h8000, 16'h8000, 1'b0);
      arith("R3 0-min",   3'd2, 16'h0000, 16'h8000, 1'b0);
      arith("R3 -1-max",  3'd2, 16'hFFFF, 16'h7FFF, 1'b0);

      // R6 wide sign position
      step("R6 wide xfer bit7 only", 3'd4, 0, 0, 16'h0080, 0, 0, 0, 0, 3'b000, 0, 0);
      step("R6 wide xfer bit15", 3'd4, 0, 0, 16'h8000, 0, 0, 0, 0, 3'b000, 0, 0);

      // R2 mode control
      cmd("R2 set mode", 1, 0, 3'b001, 0, 0);
      cmd("R2 clear-mode", 0, 0, 3'b000, 1, 0);
      cmd("R2 set mode again", 1, 0, 3'b001, 0, 0);
      cmd("R2 clear-flags mode", 0, 1, 3'b001, 0, 0);
      cmd("R2 set mode final", 1, 0, 3'b001, 0, 0);

      // R4 narrow sweep with unrelated upper bytes
      for (int i = 0; i < 256; i += 5) begin
         for (int j = 0; j < 256; j += 5) begin
            logic [15:0] a, b;
            a = {8'($urandom_range(255)), 8'(i)};
            b = {8'($urandom_range(255)), 8'(j)};
            arith("R4 narrow add", 3'd1, a, b, 1'b0);
            arith("R4 narrow sub", 3'd2, a, b, 1'b0);
         end
      end
      arith("R4 127+1",    3'd1, 16'h007F, 16'h0001, 1'b0);
      arith("R4 -128-1",   3'd2, 16'h0080, 16'h0001, 1'b0);
      arith("R4 high garbage", 3'd1, 16'h7F10, 16'h7F20, 1'b0);

      // R6 narrow sign position and transfer keeps ovf
      cmd("R6 prep set ovf", 1, 0, 3'b010, 0, 0);
      step("R6 narrow xfer bit7", 3'd4, 0, 0, 16'h0080, 0, 0, 0, 0, 3'b000, 0, 0);
      step("R6 narrow xfer bit15", 3'd4, 0, 0, 16'h8000, 0, 0, 0, 0, 3'b000, 0, 0);

      // R7 decimal freeze
      for (int k = 0; k < 200; k++) begin
         cmd("R7 prep", 1, 1, {($urandom_range(1) == 1), ($urandom_range(1) == 1), 1'b0} | 3'b001, 0, 0);
         arith("R7 dec add", 3'd1, 16'(k * 37), 16'(k * 91 + 100), 1'b1);
         arith("R7 dec sub", 3'd2, 16'(k * 53), 16'(200 - k), 1'b1);
      end

      // R5 divide check, including in decimal mode
      step("R5 div wide", 3'd3, 0, 0, 16'hFFFF, 1, 0, 0, 0, 3'b000, 0, 0);
      step("R5 div fits", 3'd3, 0, 0, 16'hFFFF, 0, 0, 0, 0, 3'b000, 0, 0);
      step("R5 div wide dec", 3'd3, 0, 0, 16'h0000, 1, 1, 0, 0, 3'b000, 0, 0);

      // R9 command priority
      step("R9 clv beats add ovf", 3'd1, 16'h007F, 16'h0001, 16'h0080, 0, 0, 0, 0, 3'b000, 0, 1);
      step("R9 set beats add", 3'd1, 16'h0001, 16'h0001, 16'h0002, 0, 0, 1, 0, 3'b010, 0, 0);
      step("R9 set beats clear", 3'd0, 0, 0, 0, 0, 0, 1, 1, 3'b110, 0, 0);
      step("R9 clear neg beats xfer", 3'd4, 0, 0, 16'h0080, 0, 0, 0, 1, 3'b100, 0, 0);
      step("R9 set mode beats clear-mode", 3'd0, 0, 0, 0, 0, 0, 1, 0, 3'b001, 1, 0);
      step("R11 nop final", 3'd0, 16'h1234, 16'h5678, 16'h9ABC, 1, 1, 0, 0, 3'b000, 0, 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule